// File: doc/BRIEF.md
# NAND Bus Strobe Timing Generator

This block turns single bus-cycle requests into correctly timed strobes on an 8-bit NAND flash bus. A requester presents a cycle type (command, address, data write or data read) and a byte on a valid/ready handshake. The generator then asserts chip enable, waits the programmed chip-enable-to-data delay, inserts a bus turnaround gap when the data direction changes, and produces the low and high phases of the write or read strobe. The byte captured on a read comes back with a single-cycle done pulse.

All phase lengths come from one packed 32-bit timing word, one field per phase, each counted in controller clock cycles. Software typically sets each field from the ratio of the controller clock to the target rate. After a command or address cycle, the block masks the ready/busy line for a programmable number of cycles so that a stale ready level is not seen. The timing word is sampled only while the generator is idle.

Top module: `nand_strobe_gen`

## Requirements
- R1: After reset, chip enable, read strobe and write strobe are all high (inactive). CLE, ALE, bus drive and done are low, and the request port is ready.
- R2: The timing word fields are: write-low in bits 3:0, write-high in bits 7:4, read-low in bits 11:8, read-high in bits 15:12, turnaround in bits 18:16, busy-mask in bits 23:19 and chip-enable-to-data delay in bits 25:24. Bits 31:26 are ignored. Each field is a count of clock cycles.
- R3: A field value of zero yields a one-cycle phase, so no phase is ever zero cycles long.
- R4: The cycle type encodings are command=0, address=1, data write=2 and data read=3. Command, address and data write cycles hold the write strobe low for the write-low count, then high for the write-high count. The byte is driven and stable on the bus throughout. CLE is high only for command cycles and ALE only for address cycles.
- R5: A read cycle holds the read strobe low for the read-low count, then high for the read-high count. The bus is never driven during a read. The byte returned is the bus value sampled in the last low cycle.
- R6: A request accepted while chip enable is high drives chip enable low at once and delays the first strobe by the chip-enable-to-data count. Chip enable stays low, with no delay, for a request accepted in the cycle right after done. It goes high after an idle cycle with no request.
- R7: When a cycle's direction (read versus any write type) differs from the previous cycle's direction, the bus stays undriven and both strobes stay high for the turnaround count before the strobe phase. No gap is inserted between cycles of the same direction.
- R8: When a command or address cycle completes, the ready output is forced low for the busy-mask count and then follows the ready/busy input. Data cycles do not start this window.
- R9: The port accepts a request only while idle. Each request yields exactly one single-cycle done pulse, which appears in the cycle after the last strobe-high cycle.
- R10: Changes to the timing word while a cycle is in progress have no effect on that cycle. The value present at acceptance governs the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| timing_i | input | 32 | Packed timing word |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_type_i | input | 2 | Cycle type |
| req_data_i | input | DATA_W | Byte for command, address or write |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_data_o | output | DATA_W | Byte captured by the last read |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_dq_o | output | DATA_W | Bus output data |
| nand_dq_oe_o | output | 1 | Bus output enable |
| nand_dq_i | input | DATA_W | Bus input data |
| nand_rb_i | input | 1 | Ready/busy from the flash, high when ready |
| rb_ok_o | output | 1 | Ready/busy after the busy mask window |

## Verification
The bench builds the block with the default 8-bit data width and the fixed 5-bit phase counters. Because all timing comes from the run-time word, the bench programs several words that cover all-zero fields, asymmetric low and high counts, and a 6-cycle busy mask. Chained requests reach back-to-back cycles with and without turnaround. A bus value that changes on every read-low cycle shows which cycle the read data is sampled in.

// File: rtl/nand_strobe_pkg.sv
package nand_strobe_pkg;

  localparam int unsigned CNT_W = 5;

  typedef enum logic [1:0] {
    CYC_CMD  = 2'd0,
    CYC_ADDR = 2'd1,
    CYC_WR   = 2'd2,
    CYC_RD   = 2'd3
  } cyc_e;

  // field order is the bit order of the timing word (MSB first)
  typedef struct packed {
    logic [1:0] ce_dly;
    logic [4:0] bsy_dly;
    logic [2:0] ta;
    logic [3:0] rd_hi;
    logic [3:0] rd_lo;
    logic [3:0] wr_hi;
    logic [3:0] wr_lo;
  } tcfg_t;

  localparam int unsigned TCFG_W = $bits(tcfg_t);

  function automatic logic [CNT_W-1:0] eff_len(input logic [CNT_W-1:0] f);
    return (f == '0) ? CNT_W'(1) : f;
  endfunction

endpackage

// File: rtl/nand_phase_cnt.sv
module nand_phase_cnt
  import nand_strobe_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         last_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign last_o = (cnt_q == W'(1));

  AST_LOAD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (val_i != '0)); // R3

endmodule

// File: rtl/nand_busy_win.sv
module nand_busy_win
  import nand_strobe_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] len_i,
  input  logic         rb_i,
  output logic         rb_ok_o
);

  logic [W-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            win_q <= '0;
    else if (start_i)       win_q <= len_i;
    else if (win_q != '0)   win_q <= win_q - W'(1);
  end

  assign rb_ok_o = (win_q == '0) && rb_i;

  AST_RB_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !rb_ok_o); // R8

  AST_RB_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_ok_o |-> rb_i); // R8

endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nand_strobe_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       timing_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_type_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              rsp_done_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              nand_ce_no,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_re_no,
  output logic              nand_we_no,
  output logic [DATA_W-1:0] nand_dq_o,
  output logic              nand_dq_oe_o,
  input  logic [DATA_W-1:0] nand_dq_i,
  output logic              cnt_load_o,
  output logic [CNT_W-1:0]  cnt_val_o,
  input  logic              cnt_last_i,
  output logic              bsy_start_o,
  output logic [CNT_W-1:0]  bsy_len_o
);

  typedef enum logic [2:0] {S_IDLE, S_CE, S_TA, S_LO, S_HI} st_e;

  st_e               st_q, st_d;
  tcfg_t             tq, tsel;
  cyc_e              typ_q;
  logic [DATA_W-1:0] dat_q, rd_q;
  logic              ce_n_q, prev_rd_q, has_prev_q, ta_pend_q, done_q;
  logic              accept, acc_rd, acc_ta, cur_rd, strobe_ph;
  logic              unused_rsvd;

  assign unused_rsvd = ^timing_i[31:TCFG_W];

  function automatic logic [CNT_W-1:0] lo_len(input tcfg_t t, input logic rd);
    return eff_len(rd ? CNT_W'(t.rd_lo) : CNT_W'(t.wr_lo));
  endfunction

  function automatic logic [CNT_W-1:0] hi_len(input tcfg_t t, input logic rd);
    return eff_len(rd ? CNT_W'(t.rd_hi) : CNT_W'(t.wr_hi));
  endfunction

  assign tsel   = (st_q == S_IDLE) ? tcfg_t'(timing_i[TCFG_W-1:0]) : tq;
  assign accept = req_valid_i && (st_q == S_IDLE);
  assign acc_rd = (cyc_e'(req_type_i) == CYC_RD);
  assign acc_ta = has_prev_q && (prev_rd_q != acc_rd);
  assign cur_rd = (typ_q == CYC_RD);

  always_comb begin
    st_d       = st_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    unique case (st_q)
      S_IDLE: if (accept) begin
        cnt_load_o = 1'b1;
        if (ce_n_q) begin
          st_d      = S_CE;
          cnt_val_o = eff_len(CNT_W'(tsel.ce_dly));
        end else if (acc_ta) begin
          st_d      = S_TA;
          cnt_val_o = eff_len(CNT_W'(tsel.ta));
        end else begin
          st_d      = S_LO;
          cnt_val_o = lo_len(tsel, acc_rd);
        end
      end
      S_CE: if (cnt_last_i) begin
        cnt_load_o = 1'b1;
        if (ta_pend_q) begin
          st_d      = S_TA;
          cnt_val_o = eff_len(CNT_W'(tq.ta));
        end else begin
          st_d      = S_LO;
          cnt_val_o = lo_len(tq, cur_rd);
        end
      end
      S_TA: if (cnt_last_i) begin
        st_d       = S_LO;
        cnt_load_o = 1'b1;
        cnt_val_o  = lo_len(tq, cur_rd);
      end
      S_LO: if (cnt_last_i) begin
        st_d       = S_HI;
        cnt_load_o = 1'b1;
        cnt_val_o  = hi_len(tq, cur_rd);
      end
      S_HI: if (cnt_last_i) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      tq         <= '0;
      typ_q      <= CYC_CMD;
      dat_q      <= '0;
      rd_q       <= '0;
      ce_n_q     <= 1'b1;
      prev_rd_q  <= 1'b0;
      has_prev_q <= 1'b0;
      ta_pend_q  <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == S_HI) && cnt_last_i;
      if (st_q == S_IDLE) begin
        tq     <= tcfg_t'(timing_i[TCFG_W-1:0]);
        ce_n_q <= !req_valid_i;
      end
      if (accept) begin
        typ_q      <= cyc_e'(req_type_i);
        dat_q      <= req_data_i;
        prev_rd_q  <= acc_rd;
        has_prev_q <= 1'b1;
        ta_pend_q  <= acc_ta;
      end
      if ((st_q == S_LO) && cnt_last_i && cur_rd) rd_q <= nand_dq_i;
    end
  end

  assign strobe_ph    = (st_q == S_LO) || (st_q == S_HI);
  assign req_ready_o  = (st_q == S_IDLE);
  assign rsp_done_o   = done_q;
  assign rsp_data_o   = rd_q;
  assign nand_ce_no   = ce_n_q;
  assign nand_cle_o   = strobe_ph && (typ_q == CYC_CMD);
  assign nand_ale_o   = strobe_ph && (typ_q == CYC_ADDR);
  assign nand_re_no   = !((st_q == S_LO) && cur_rd);
  assign nand_we_no   = !((st_q == S_LO) && !cur_rd);
  assign nand_dq_oe_o = strobe_ph && !cur_rd;
  assign nand_dq_o    = dat_q;
  assign bsy_start_o  = (st_q == S_HI) && cnt_last_i &&
                        ((typ_q == CYC_CMD) || (typ_q == CYC_ADDR));
  assign bsy_len_o    = eff_len(CNT_W'(tq.bsy_dly));

  AST_CE_BEFORE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_re_no || !nand_we_no) |-> !nand_ce_no); // R6

  AST_RD_BUS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_re_no |-> !nand_dq_oe_o); // R5

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o); // R9

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> $stable(dat_q)); // R9

  AST_TIMING_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != S_IDLE) |=> $stable(tq)); // R10

  AST_WR_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nand_dq_oe_o && $past(nand_dq_oe_o)) |-> $stable(nand_dq_o)); // R4

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nand_strobe_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       timing_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_type_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              rsp_done_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              nand_ce_no,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_re_no,
  output logic              nand_we_no,
  output logic [DATA_W-1:0] nand_dq_o,
  output logic              nand_dq_oe_o,
  input  logic [DATA_W-1:0] nand_dq_i,
  input  logic              nand_rb_i,
  output logic              rb_ok_o
);

  logic             cnt_load, cnt_last, bsy_start;
  logic [CNT_W-1:0] cnt_val, bsy_len;

  nand_strobe_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .timing_i     (timing_i),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_type_i   (req_type_i),
    .req_data_i   (req_data_i),
    .rsp_done_o   (rsp_done_o),
    .rsp_data_o   (rsp_data_o),
    .nand_ce_no   (nand_ce_no),
    .nand_cle_o   (nand_cle_o),
    .nand_ale_o   (nand_ale_o),
    .nand_re_no   (nand_re_no),
    .nand_we_no   (nand_we_no),
    .nand_dq_o    (nand_dq_o),
    .nand_dq_oe_o (nand_dq_oe_o),
    .nand_dq_i    (nand_dq_i),
    .cnt_load_o   (cnt_load),
    .cnt_val_o    (cnt_val),
    .cnt_last_i   (cnt_last),
    .bsy_start_o  (bsy_start),
    .bsy_len_o    (bsy_len)
  );

  nand_phase_cnt #(.W(CNT_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .val_i  (cnt_val),
    .last_o (cnt_last)
  );

  nand_busy_win #(.W(CNT_W)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (bsy_start),
    .len_i   (bsy_len),
    .rb_i    (nand_rb_i),
    .rb_ok_o (rb_ok_o)
  );

  AST_CLE_ALE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o)); // R4

  AST_CTRL_IN_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nand_cle_o || nand_ale_o) |-> !nand_ce_no); // R4

endmodule

// File: tb/nand_strobe_gen_tb_top.sv
module nand_strobe_gen_tb_top;
  import nand_strobe_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] timing_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [1:0]  req_type_i = '0;
  logic [7:0]  req_data_i = '0;
  logic        rsp_done_o;
  logic [7:0]  rsp_data_o;
  logic        nand_ce_no, nand_cle_o, nand_ale_o, nand_re_no, nand_we_no;
  logic [7:0]  nand_dq_o;
  logic        nand_dq_oe_o;
  logic [7:0]  nand_dq_i = '0;
  logic        nand_rb_i = 1'b1;
  logic        rb_ok_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  nand_strobe_gen #(.DATA_W(8)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .timing_i(timing_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_type_i(req_type_i), .req_data_i(req_data_i),
    .rsp_done_o(rsp_done_o), .rsp_data_o(rsp_data_o),
    .nand_ce_no(nand_ce_no), .nand_cle_o(nand_cle_o), .nand_ale_o(nand_ale_o),
    .nand_re_no(nand_re_no), .nand_we_no(nand_we_no),
    .nand_dq_o(nand_dq_o), .nand_dq_oe_o(nand_dq_oe_o), .nand_dq_i(nand_dq_i),
    .nand_rb_i(nand_rb_i), .rb_ok_o(rb_ok_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // R2 field layout
  function automatic logic [31:0] mk(input int ce, input int bsy, input int ta,
                                     input int rh, input int rl, input int wh, input int wl);
    return {6'h2A, ce[1:0], bsy[4:0], ta[2:0], rh[3:0], rl[3:0], wh[3:0], wl[3:0]};
  endfunction

  function automatic int e(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  // Called at a negedge; returns at the negedge where done is seen.
  task automatic run_req(input cyc_e ty, input logic [7:0] d, input bit chg,
                         input logic [31:0] t_new,
                         output int pre, output int lo, output int tot,
                         output logic [7:0] rdat, output bit cle_s, output bit ale_s,
                         output bit bus_bad, output bit rdy_bad);
    pre = 0; lo = 0; tot = 0; cle_s = 0; ale_s = 0; bus_bad = 0; rdy_bad = 0;
    req_valid_i = 1'b1;
    req_type_i  = ty;
    req_data_i  = d;
    while (!req_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (chg) timing_i = t_new;
    while (!rsp_done_o) begin
      tot++;
      if (req_ready_o) rdy_bad = 1;
      if (!nand_re_no || !nand_we_no) begin
        if (!nand_re_no) begin
          nand_dq_i = 8'hA0 + 8'(lo);
          if (nand_dq_oe_o) bus_bad = 1;
        end else if (!nand_dq_oe_o || nand_dq_o != d) bus_bad = 1;
        lo++;
      end else if (lo == 0) begin
        pre++;
        if (nand_dq_oe_o) bus_bad = 1;
      end
      if (nand_cle_o) cle_s = 1;
      if (nand_ale_o) ale_s = 1;
      if (tot > 200) break;
      @(negedge clk_i);
    end
    rdat = rsp_data_o;
  endtask

  int pre, lo, tot;
  logic [7:0] rdat;
  bit cle_s, ale_s, bus_bad, rdy_bad;

  task automatic t_reset();
    @(negedge clk_i);
    check_eq("R1 ce_n", nand_ce_no, 1);
    check_eq("R1 re_n", nand_re_no, 1);
    check_eq("R1 we_n", nand_we_no, 1);
    check_eq("R1 cle/ale/oe", {nand_cle_o, nand_ale_o, nand_dq_oe_o}, 0);
    check_eq("R1 ready", req_ready_o, 1);
    check_eq("R1 done", rsp_done_o, 0);
  endtask

  task automatic t_write_then_read();
    timing_i = mk(2, 6, 4, 3, 4, 2, 3);
    run_req(CYC_WR, 8'h5A, 0, '0, pre, lo, tot, rdat, cle_s, ale_s, bus_bad, rdy_bad);
    check_eq("R6 write ce delay", pre, 2);
    check_eq("R4 write low", lo, 3);
    check_eq("R4 write total", tot, 2 + 3 + 2);
    check_eq("R4 write cle/ale", {cle_s, ale_s}, 0);
    check_eq("R4 write bus", bus_bad, 0);
    check_eq("R9 ready while busy", rdy_bad, 0);
    @(negedge clk_i);
    check_eq("R6 ce released", nand_ce_no, 1);
    run_req(CYC_RD, 8'h00, 0, '0, pre, lo, tot, rdat, cle_s, ale_s, bus_bad, rdy_bad);
    check_eq("R7 ce+turnaround", pre, 2 + 4);
    check_eq("R5 read low", lo, 4);
    check_eq("R5 read total", tot, 6 + 4 + 3);
    check_eq("R5 read data last low", rdat, 8'hA3);
    check_eq("R5 read bus undriven", bus_bad, 0);
  endtask

  task automatic t_zero_fields();
    timing_i = 32'h0;
    @(negedge clk_i);
    run_req(CYC_RD, 8'h00, 0, '0, pre, lo, tot, rdat, cle_s, ale_s, bus_bad, rdy_bad);
    check_eq("R3 zero ce", pre, 1);
    check_eq("R3 zero read low", lo, 1);
    check_eq("R3 zero total", tot, 3);
    check_eq("R3 read data", rdat, 8'hA0);
    run_req(CYC_WR, 8'h33, 0, '0, pre, lo, tot, rdat, cle_s, ale_s, bus_bad, rdy_bad);
    check_eq("R3 zero turnaround", pre, 1);
    check_eq("R3 zero write total", tot, 3);
  endtask

  task automatic t_busy();
    int n;
    timing_i = mk(1, 6, 2, 1, 1, 1, 1);
    @(negedge clk_i);
    nand_rb_i = 1'b1;
    run_req(CYC_CMD, 8'h70, 0, '0, pre, lo, tot, rdat, cle_s, ale_s, bus_bad, rdy_bad);
    check_eq("R4 cmd cle only", {cle_s, ale_s}, 2'b10);
    check_eq("R4 cmd total", tot, 3);
    n = 0;
    while (!rb_ok_o && n < 50) begin n++; @(negedge clk_i); end
    check_eq("R8 busy mask length", n, 6);
    nand_rb_i = 1'b0;
    #1 check_eq("R8 follows rb low", rb_ok_o, 0);
    nand_rb_i = 1'b1;
    #1 check_eq("R8 follows rb high", rb_ok_o, 1);
    @(negedge clk_i);
    run_req(CYC_WR, 8'h11, 0, '0, pre, lo, tot, rdat, cle_s, ale_s, bus_bad, rdy_bad);
    check_eq("R8 data no mask", rb_ok_o, 1);
    check_eq("R4 data no cle/ale", {cle_s, ale_s}, 0);
    @(negedge clk_i);
    run_req(CYC_ADDR, 8'h22, 0, '0, pre, lo, tot, rdat, cle_s, ale_s, bus_bad, rdy_bad);
    check_eq("R4 addr ale only", {cle_s, ale_s}, 2'b01);
    check_eq("R8 addr starts mask", rb_ok_o, 0);
    repeat (8) @(negedge clk_i);
  endtask

  task automatic t_chain();
    timing_i = mk(1, 1, 3, 2, 2, 2, 2);
    @(negedge clk_i);
    run_req(CYC_ADDR, 8'h01, 0, '0, pre, lo, tot, rdat, cle_s, ale_s, bus_bad, rdy_bad);
    check_eq("R6 first ce delay", pre, 1);
    check_eq("R6 first total", tot, 5);
    run_req(CYC_ADDR, 8'h02, 0, '0, pre, lo, tot, rdat, cle_s, ale_s, bus_bad, rdy_bad);
    check_eq("R6 chained no ce delay", pre, 0);
    check_eq("R7 same dir no gap total", tot, 4);
    run_req(CYC_RD, 8'h00, 0, '0, pre, lo, tot, rdat, cle_s, ale_s, bus_bad, rdy_bad);
    check_eq("R7 turnaround only", pre, 3);
    check_eq("R7 read total", tot, 7);
    check_eq("R5 chained read data", rdat, 8'hA1);
    check_eq("R9 ready while busy", rdy_bad, 0);
  endtask

  task automatic t_timing_change();
    repeat (2) @(negedge clk_i);
    timing_i = mk(1, 1, 1, 1, 1, 1, 2);
    run_req(CYC_WR, 8'h44, 1, mk(1, 1, 1, 1, 1, 1, 7),
            pre, lo, tot, rdat, cle_s, ale_s, bus_bad, rdy_bad);
    check_eq("R10 old write low held", lo, 2);
    @(negedge clk_i);
    run_req(CYC_WR, 8'h45, 0, '0, pre, lo, tot, rdat, cle_s, ale_s, bus_bad, rdy_bad);
    check_eq("R10 new write low", lo, e(7));
    check_eq("R2 reserved bits ignored", tot, 1 + 7 + 1);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_write_then_read();
    t_zero_fields();
    t_busy();
    t_chain();
    t_timing_change();
    repeat (3) @(negedge clk_i);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9 actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule